// File: doc/BRIEF.md
# Li-Ion Charge Cycle Sequencer

This block is the digital sequencer of a linear lithium-ion charger. It reads synchronous comparator flags: input power valid, battery under the short threshold, battery under the precharge threshold, battery at the regulation voltage, charge current under the termination level, battery under the recharge level, thermistor fault and chip disable. From these flags it walks each charge cycle through short recovery, precharge, constant current and constant voltage, and then to done. The analog regulation loops and the current DACs sit outside the block. The sequencer only tells them which current setpoint to apply.

Time comes from a millisecond tick input. A programmable safety-timer length, given in minutes, bounds the whole cycle. One tenth of that length bounds the low-current phases. When the timer expires the block enters a latched fault phase. A thermistor fault pauses charging and freezes the timer without leaving the current phase. An active-low status line is pulled low while a cycle is in progress. A fixed-width fault pulse request marks each fault event for the host interrupt line.

Top module: `charge_sequencer`

## Requirements
- R1: After reset the phase is off (code 0). On leaving off, the first phase is short recovery (code 1) if the short flag is set, otherwise precharge (code 2) if the low flag is set, otherwise constant current (code 3).
- R2: Short recovery moves on when the short flag clears: to precharge if the low flag is set, else to constant current. Precharge moves to constant current when the low flag clears, and back to short recovery if the short flag sets. Constant current moves to constant voltage (code 4) when the at-regulation flag is set.
- R3: The current select is 1 (small setpoint, the same value used for termination) in short recovery and precharge, 2 (fast setpoint) in constant current and constant voltage, and 0 (no current) in every other phase.
- R4: Constant voltage moves to done (code 5) only once the below-termination flag has been high for TERM_MS consecutive ticks. The filtered flag falls only after the raw flag has been low for TERM_MS consecutive ticks, so any shorter change of the raw flag is ignored.
- R5: In done, a new cycle starts, with its phase chosen as in R1, only after the below-recharge flag has been high for RCH_MS consecutive ticks.
- R6: Whenever input valid is low or chip disable is high, the phase goes to off on the next clock. When input is valid and disable is low again, a new cycle starts as in R1.
- R7: The safety timer restarts at each cycle start and counts ticks in the charging phases. In short recovery or precharge, reaching timerMin*MS_PER_MIN/10 ticks gives fault (code 6). In constant current or constant voltage, reaching timerMin*MS_PER_MIN ticks gives fault.
- R8: The fault phase is held until input valid goes low or chip disable goes high.
- R9: While the thermistor fault flag is high in a charging phase, the phase is held, the current select is 0 and the safety timer does not advance. When the flag clears, charging continues in the same phase.
- R10: statusN is 0 in phases 1 to 4, including while paused, and 1 in off, done and fault.
- R11: Each fault event produces exactly one faultPulse of PULSE_CYC clock cycles. A fault event is entry into the fault phase, or a rising thermistor fault flag during a charging phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| msTick | input | 1 | One-cycle strobe once per millisecond |
| timerMin | input | TMR_W | Safety timer length in minutes |
| inValid | input | 1 | Input power valid |
| chipDis | input | 1 | Chip disable, stops charging |
| batShort | input | 1 | Battery under short threshold (hysteretic comparator) |
| batLow | input | 1 | Battery under precharge threshold |
| batAtReg | input | 1 | Battery at regulation voltage |
| iBelowTerm | input | 1 | Charge current under termination level |
| batBelowRch | input | 1 | Battery under recharge level |
| tsFault | input | 1 | Thermistor out of range |
| phase | output | 3 | Phase code: 0 off, 1 short, 2 pre, 3 CC, 4 CV, 5 done, 6 fault |
| curSel | output | 2 | Current setpoint: 0 none, 1 small, 2 fast |
| statusN | output | 1 | Active-low charging status |
| faultPulse | output | 1 | Fault interrupt pulse request |

## Verification
The bench builds the block with MS_PER_MIN = 100 and PULSE_CYC = 4, keeps the deglitch windows at 64 and 32 ticks, and drives a tick every clock. With these values a 2-minute setting expires after 200 ticks in constant current and after 20 ticks in precharge. This puts both timeouts, the pause that freezes the timer, and the latched fault within a few hundred cycles. A 10-minute setting keeps the timer out of the way while the bench checks the phase walk, a termination glitch shorter than the window, and the recharge restart.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [2:0] {
    PH_OFF   = 3'd0,
    PH_SHORT = 3'd1,
    PH_PRE   = 3'd2,
    PH_CC    = 3'd3,
    PH_CV    = 3'd4,
    PH_DONE  = 3'd5,
    PH_FAULT = 3'd6
  } phase_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PRE  = 2'd1,
    SEL_FAST = 2'd2
  } isel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic tmrClr;
    logic tmrRun;
    logic pulseReq;
  } strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic preExp;
    logic mainExp;
    logic termOk;
    logic rchOk;
  } dpstat_t;
endpackage

// File: rtl/chg_deglitch.sv
module chg_deglitch #(
  parameter int HOLD_MS = 64,
  localparam int CW = $clog2(HOLD_MS + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic raw,
  output logic filt
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      filt <= 1'b0;
    end else if (raw == filt) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == CW'(HOLD_MS - 1)) begin
        filt <= raw;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4 / R5: filtered flag only ever moves toward the raw value seen before
  p_filt_follows_raw_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filt) |-> (filt == $past(raw)));
endmodule

// File: rtl/chg_datapath.sv
module chg_datapath
  import chg_pkg::*;
#(
  parameter int MS_PER_MIN = 60000,
  parameter int TMR_W      = 10,
  parameter int PULSE_CYC  = 25600,
  parameter int TERM_MS    = 64,
  parameter int RCH_MS     = 32,
  localparam int CNT_W = $clog2(((2 ** TMR_W) - 1) * MS_PER_MIN + 1),
  localparam int PW    = $clog2(PULSE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msTick,
  input  logic [TMR_W-1:0] timerMin,
  input  logic             iBelowTerm,
  input  logic             batBelowRch,
  input  strobe_t          strb,
  output dpstat_t          st,
  output logic             faultPulse
);
  logic [CNT_W-1:0] tmrCnt;
  logic [CNT_W-1:0] mainLim;
  logic [CNT_W-1:0] preLim;
  logic [PW-1:0]    pulseCnt;
  logic             termFilt;
  logic             rchFilt;

  assign mainLim = CNT_W'(timerMin) * CNT_W'(MS_PER_MIN);
  assign preLim  = CNT_W'(timerMin) * CNT_W'(MS_PER_MIN / 10);

  // safety timer: elapsed ms of the running cycle, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (strb.tmrClr) begin
      tmrCnt <= '0;
    end else if (strb.tmrRun && msTick && (tmrCnt != '1)) begin
      tmrCnt <= tmrCnt + 1'b1;
    end
  end

  chg_deglitch #(.HOLD_MS(TERM_MS)) uTerm (
    .clk(clk), .rstN(rstN), .tick(msTick), .raw(iBelowTerm), .filt(termFilt));
  chg_deglitch #(.HOLD_MS(RCH_MS)) uRch (
    .clk(clk), .rstN(rstN), .tick(msTick), .raw(batBelowRch), .filt(rchFilt));

  // fault pulse stretcher, one pulse per request, requests during a pulse dropped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end else if (strb.pulseReq) begin
      pulseCnt <= PW'(PULSE_CYC);
    end
  end

  assign faultPulse = (pulseCnt != '0);
  assign st.preExp  = (tmrCnt >= preLim);
  assign st.mainExp = (tmrCnt >= mainLim);
  assign st.termOk  = termFilt;
  assign st.rchOk   = rchFilt;

  // R11: a started pulse lasts more than one cycle
  p_pulse_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultPulse) |=> faultPulse);
  // R9: timer frozen while control withholds run and clear
  p_timer_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tmrRun && !strb.tmrClr) |=> (tmrCnt == $past(tmrCnt)));
endmodule

// File: rtl/chg_ctrl.sv
module chg_ctrl
  import chg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    chipDis,
  input  logic    batShort,
  input  logic    batLow,
  input  logic    batAtReg,
  input  logic    tsFault,
  input  dpstat_t st,
  output phase_e  phase,
  output logic    charging,
  output strobe_t strb
);
  phase_e nextPh;
  phase_e startPh;
  logic   tsPrev;
  logic   enabled;

  assign enabled  = inValid && !chipDis;
  assign charging = (phase == PH_SHORT) || (phase == PH_PRE) ||
                    (phase == PH_CC) || (phase == PH_CV);
  assign startPh  = batShort ? PH_SHORT : (batLow ? PH_PRE : PH_CC);

  always_comb begin
    nextPh      = phase;
    strb.tmrClr = 1'b0;
    if (!enabled) begin
      nextPh = PH_OFF;
    end else begin
      unique case (phase)
        PH_OFF: begin
          nextPh      = startPh;
          strb.tmrClr = 1'b1;
        end
        PH_SHORT: if (!tsFault) begin
          if (st.preExp)      nextPh = PH_FAULT;
          else if (!batShort) nextPh = batLow ? PH_PRE : PH_CC;
        end
        PH_PRE: if (!tsFault) begin
          if (st.preExp)      nextPh = PH_FAULT;
          else if (batShort)  nextPh = PH_SHORT;
          else if (!batLow)   nextPh = PH_CC;
        end
        PH_CC: if (!tsFault) begin
          if (st.mainExp)     nextPh = PH_FAULT;
          else if (batAtReg)  nextPh = PH_CV;
        end
        PH_CV: if (!tsFault) begin
          if (st.mainExp)     nextPh = PH_FAULT;
          else if (st.termOk) nextPh = PH_DONE;
        end
        PH_DONE: if (st.rchOk) begin
          nextPh      = startPh;
          strb.tmrClr = 1'b1;
        end
        PH_FAULT: nextPh = PH_FAULT;
        default:  nextPh = PH_OFF;
      endcase
    end
  end

  assign strb.tmrRun   = charging && !tsFault;
  assign strb.pulseReq = ((nextPh == PH_FAULT) && (phase != PH_FAULT)) ||
                         (charging && enabled && tsFault && !tsPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_OFF;
      tsPrev <= 1'b0;
    end else begin
      phase  <= nextPh;
      tsPrev <= tsFault;
    end
  end

  p_off_no_input_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid || chipDis) |=> (phase == PH_OFF));
  p_fault_latched_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_FAULT && inValid && !chipDis) |=> (phase == PH_FAULT));
  p_done_after_term_r4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CV && !st.termOk) |=> (phase != PH_DONE));
  p_pre_timeout_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_SHORT || phase == PH_PRE) && st.preExp && inValid && !chipDis && !tsFault)
      |=> (phase == PH_FAULT));
  p_pause_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (charging && tsFault && inValid && !chipDis) |=> (phase == $past(phase)));
endmodule

// File: rtl/charge_sequencer.sv
module charge_sequencer
  import chg_pkg::*;
#(
  parameter int MS_PER_MIN = 60000,
  parameter int TMR_W      = 10,
  parameter int PULSE_CYC  = 25600,
  parameter int TERM_MS    = 64,
  parameter int RCH_MS     = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msTick,
  input  logic [TMR_W-1:0] timerMin,
  input  logic             inValid,
  input  logic             chipDis,
  input  logic             batShort,
  input  logic             batLow,
  input  logic             batAtReg,
  input  logic             iBelowTerm,
  input  logic             batBelowRch,
  input  logic             tsFault,
  output logic [2:0]       phase,
  output logic [1:0]       curSel,
  output logic             statusN,
  output logic             faultPulse
);
  phase_e  phaseQ;
  strobe_t strb;
  dpstat_t st;
  logic    charging;
  isel_e   sel;

  chg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .chipDis(chipDis),
    .batShort(batShort), .batLow(batLow), .batAtReg(batAtReg),
    .tsFault(tsFault), .st(st), .phase(phaseQ), .charging(charging),
    .strb(strb));

  chg_datapath #(
    .MS_PER_MIN(MS_PER_MIN), .TMR_W(TMR_W), .PULSE_CYC(PULSE_CYC),
    .TERM_MS(TERM_MS), .RCH_MS(RCH_MS)
  ) uDp (
    .clk(clk), .rstN(rstN), .msTick(msTick), .timerMin(timerMin),
    .iBelowTerm(iBelowTerm), .batBelowRch(batBelowRch), .strb(strb),
    .st(st), .faultPulse(faultPulse));

  always_comb begin
    sel = SEL_NONE;
    if (!tsFault) begin
      if (phaseQ == PH_SHORT || phaseQ == PH_PRE)   sel = SEL_PRE;
      else if (phaseQ == PH_CC || phaseQ == PH_CV) sel = SEL_FAST;
    end
  end

  assign phase   = phaseQ;
  assign curSel  = sel;
  assign statusN = !charging;

  // R3: no current outside the charging phases
  p_no_current_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd0 || phase == 3'd5 || phase == 3'd6) |-> (curSel == 2'd0));
endmodule

// File: tb/charge_sequencer_test.sv
module charge_sequencer_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       msTick = 1'b1;
  logic [9:0] timerMin = 10'd10;
  logic inValid = 0, chipDis = 0, batShort = 0, batLow = 0;
  logic batAtReg = 0, iBelowTerm = 0, batBelowRch = 0, tsFault = 0;
  logic [2:0] phase;
  logic [1:0] curSel;
  logic statusN, faultPulse;

  int checks = 0;
  int errors = 0;
  int pulseCyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  charge_sequencer #(.MS_PER_MIN(100), .TMR_W(10), .PULSE_CYC(4),
                     .TERM_MS(64), .RCH_MS(32)) uut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .timerMin(timerMin),
    .inValid(inValid), .chipDis(chipDis), .batShort(batShort),
    .batLow(batLow), .batAtReg(batAtReg), .iBelowTerm(iBelowTerm),
    .batBelowRch(batBelowRch), .tsFault(tsFault), .phase(phase),
    .curSel(curSel), .statusN(statusN), .faultPulse(faultPulse));

  always @(negedge clk) if (faultPulse) pulseCyc++;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setIn(input logic [7:0] v);
    {inValid, chipDis, batShort, batLow, batAtReg, iBelowTerm, batBelowRch, tsFault} = v;
  endtask

  task automatic doReset();
    setIn(8'b0);
    rstN = 1'b0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
  endtask

  // {inputs[7:0], wait[7:0], phase[2:0], sel[1:0], statusN}
  localparam int NV = 13;
  localparam logic [21:0] VECS [NV] = '{
    {8'b00000000, 8'd3,  3'd0, 2'd0, 1'b1},
    {8'b10100000, 8'd2,  3'd1, 2'd1, 1'b0},
    {8'b10010000, 8'd2,  3'd2, 2'd1, 1'b0},
    {8'b10000000, 8'd2,  3'd3, 2'd2, 1'b0},
    {8'b10001000, 8'd2,  3'd4, 2'd2, 1'b0},
    {8'b10001100, 8'd40, 3'd4, 2'd2, 1'b0},
    {8'b10001100, 8'd40, 3'd5, 2'd0, 1'b1},
    {8'b10000010, 8'd20, 3'd5, 2'd0, 1'b1},
    {8'b10000010, 8'd20, 3'd3, 2'd2, 1'b0},
    {8'b11000000, 8'd2,  3'd0, 2'd0, 1'b1},
    {8'b10000000, 8'd2,  3'd3, 2'd2, 1'b0},
    {8'b10000001, 8'd2,  3'd3, 2'd0, 1'b0},
    {8'b10000000, 8'd2,  3'd3, 2'd2, 1'b0}
  };
  localparam string TAGS [NV] = '{"R10", "R1", "R2", "R3", "R2", "R4", "R4",
                                  "R5", "R5", "R6", "R6", "R9", "R9"};

  initial begin
    int p0;
    doReset();
    // R1: reset state
    check("R1 reset phase", phase, 0);
    check("R10 reset status", statusN, 1);
    check("R11 reset pulse", faultPulse, 0);

    timerMin = 10'd10;
    for (int i = 0; i < NV; i++) begin
      setIn(VECS[i][21:14]);
      waitCyc(int'(VECS[i][13:6]));
      check({TAGS[i], " phase"}, phase, int'(VECS[i][5:3]));
      check({TAGS[i], " sel"}, curSel, int'(VECS[i][2:1]));
      check({TAGS[i], " status"}, statusN, int'(VECS[i][0]));
    end

    // R7 / R8 / R11: precharge timeout at 20 ticks, latched, one pulse
    doReset();
    timerMin = 10'd2;
    p0 = pulseCyc;
    setIn(8'b10010000);
    waitCyc(15);
    check("R7 pre before limit", phase, 2);
    waitCyc(15);
    check("R7 pre timeout", phase, 6);
    check("R3 sel in fault", curSel, 0);
    check("R10 status in fault", statusN, 1);
    waitCyc(20);
    check("R8 fault held", phase, 6);
    check("R11 pulse width", pulseCyc - p0, 4);
    chipDis = 1'b1;
    waitCyc(2);
    check("R8 disable clears", phase, 0);
    chipDis = 1'b0;
    waitCyc(2);
    check("R6 restart after disable", phase, 2);

    // R9: thermistor pause freezes the precharge timer
    doReset();
    timerMin = 10'd2;
    setIn(8'b10010000);
    waitCyc(10);
    p0 = pulseCyc;
    tsFault = 1'b1;
    waitCyc(50);
    check("R9 paused phase", phase, 2);
    check("R9 paused sel", curSel, 0);
    check("R10 paused status", statusN, 0);
    check("R11 thermistor pulse", pulseCyc - p0, 4);
    tsFault = 1'b0;
    waitCyc(5);
    check("R9 resumed phase", phase, 2);
    check("R9 resumed sel", curSel, 1);
    waitCyc(20);
    check("R7 pre timeout after resume", phase, 6);

    // R7: main timer at 200 ticks in constant current
    doReset();
    timerMin = 10'd2;
    setIn(8'b10000000);
    waitCyc(190);
    check("R7 cc before limit", phase, 3);
    waitCyc(25);
    check("R7 main timeout", phase, 6);
    // R8: input removal clears fault
    inValid = 1'b0;
    waitCyc(2);
    check("R8 input removal clears", phase, 0);
    inValid = 1'b1;
    waitCyc(2);
    check("R1 restart to cc", phase, 3);

    // R4: short glitch in termination flag is ignored
    doReset();
    timerMin = 10'd10;
    setIn(8'b10001000);
    waitCyc(3);
    check("R2 reach cv", phase, 4);
    iBelowTerm = 1'b1; waitCyc(40);
    iBelowTerm = 1'b0; waitCyc(3);
    iBelowTerm = 1'b1; waitCyc(40);
    check("R4 glitch ignored", phase, 4);
    waitCyc(30);
    check("R4 terminate", phase, 5);

    // R2: precharge falls back to short recovery
    doReset();
    setIn(8'b10010000);
    waitCyc(2);
    batShort = 1'b1;
    waitCyc(2);
    check("R2 pre to short", phase, 1);
    batShort = 1'b0; batLow = 1'b0;
    waitCyc(2);
    check("R2 short to cc", phase, 3);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule